// File: doc/BRIEF.md
# Debug Halt and Command Gating Controller

This block keeps track of the execution state a processor core is in from a debugger's point of view: running, parked in a low-power stop or wait, halted for debug, or executing a single debugger-requested instruction. Each cycle it merges reset-cause strobes, decoded debugger commands and on-chip debug events into one next state. Each halt source has its own enable bit, and every reset cause takes priority over everything else in the same cycle.

The same block decides whether each decoded debugger command may go ahead. The decision depends on the command's class, the device security flag, the debug-enable bit and the current core state. The block answers each command with a one-cycle accept or reject pulse and raises a one-cycle halt request whenever the core enters the halted state. Serial pin handling, register storage, memory access and flash erasure belong to neighbouring blocks.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `core_state` is RUN (encoding RUN=0, LOWPWR=1, HALT=2, STEP=3), and `halt_req`, `cmd_accept` and `cmd_reject` are low.
- R2: A power-on reset strobe leads to HALT on the next cycle when `pin_low` is high, and to RUN otherwise.
- R3: A debugger-forced reset strobe leads to HALT when `pin_low` is high or `ctl_forced_halt` is set, and to RUN otherwise.
- R4: A watchdog, illegal-operand or illegal-address reset strobe leads to HALT only when that cause's own enable (`ctl_wdog_halt`, `ctl_illop_halt`, `ctl_illadr_halt`) is set, and to RUN otherwise.
- R5: In a cycle with any reset strobe, the next state comes from the reset rule alone. Commands and events in that cycle change no state, although the command still gets its accept or reject answer.
- R6: `sleep_req` moves RUN to LOWPWR and `wake_req` moves LOWPWR back to RUN. An accepted BACKGROUND command (class 1, op 1) moves RUN, LOWPWR or STEP to HALT.
- R7: `halt_insn` moves RUN or STEP to HALT only when `ctl_dbg_en` is set. Otherwise it has no effect.
- R8: In RUN or STEP, `bkpt_trig` halts the core only when `ctl_bkpt_halt` is set. `trace_full` halts the core only when `ctl_rec_mode` is 01 or 11, and not when it is 00 or 10.
- R9: Class 0 (always-available) commands are accepted in every state, whatever the values of `ctl_secure` and `ctl_dbg_en`.
- R10: Class 1 (non-intrusive) commands are accepted only when `ctl_secure` is low, `ctl_dbg_en` is high and the state is RUN, HALT or STEP. BACKGROUND is also accepted in LOWPWR.
- R11: Class 2 (active-background) commands are accepted only when the device is unsecured, debug is enabled and the state is HALT. An accepted GO (op 2) moves the state to RUN. Class 3 is always rejected.
- R12: An accepted STEP (class 2, op 3) moves HALT to STEP. In STEP, `insn_done` returns the core to HALT.
- R13: `cmd_accept` or `cmd_reject` pulses for exactly one cycle, one cycle after `cmd_valid`. A rejected command leaves the state unchanged.
- R14: `halt_req` is high for exactly one cycle: the first cycle in which `core_state` reads HALT after entering it, including re-entry through a reset cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_por | input | 1 | Power-on reset cause strobe |
| rst_forced | input | 1 | Debugger-forced reset cause strobe |
| rst_wdog | input | 1 | Watchdog reset cause strobe |
| rst_illop | input | 1 | Illegal-operand reset cause strobe |
| rst_illadr | input | 1 | Illegal-address reset cause strobe |
| pin_low | input | 1 | Sampled debug pin level is low |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_class | input | 2 | Command class (0 always, 1 non-intrusive, 2 active, 3 reserved) |
| cmd_op | input | 2 | Command op (0 plain, 1 BACKGROUND, 2 GO, 3 STEP) |
| halt_insn | input | 1 | Halt instruction executed |
| bkpt_trig | input | 1 | Breakpoint trigger |
| trace_full | input | 1 | Trace buffer full |
| sleep_req | input | 1 | Core enters stop or wait |
| wake_req | input | 1 | Core wakes from stop or wait |
| insn_done | input | 1 | Instruction-complete acknowledge |
| ctl_secure | input | 1 | Device is secured |
| ctl_dbg_en | input | 1 | Debug enable bit |
| ctl_forced_halt | input | 1 | Halt after a debugger-forced reset |
| ctl_wdog_halt | input | 1 | Halt after a watchdog reset |
| ctl_illop_halt | input | 1 | Halt after an illegal-operand reset |
| ctl_illadr_halt | input | 1 | Halt after an illegal-address reset |
| ctl_bkpt_halt | input | 1 | Breakpoint response is halt |
| ctl_rec_mode | input | 2 | Trace recording mode |
| core_state | output | 2 | Current core state |
| halt_req | output | 1 | One-cycle pulse on entry to halt |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command rejected pulse |

## Verification
The state register is the only memory that controls acceptance, so a wrong internal state appears at the ports in two ways. `core_state` shows a wrong encoding on the cycle after the edge that went astray. The next command whose class depends on state gets the wrong accept or reject pulse one cycle after it is issued. A missed or repeated halt entry shows up at once as a missing or stretched `halt_req` pulse alongside `core_state`.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_LOWPWR = 2'd1,
        ST_HALT   = 2'd2,
        ST_STEP   = 2'd3
    } core_state_e;

    typedef enum logic [1:0] {
        CL_ALWAYS = 2'd0,
        CL_NONINTR = 2'd1,
        CL_ACTIVE = 2'd2,
        CL_RSVD   = 2'd3
    } cmd_class_e;

    typedef enum logic [1:0] {
        OP_PLAIN      = 2'd0,
        OP_BACKGROUND = 2'd1,
        OP_GO         = 2'd2,
        OP_STEP       = 2'd3
    } cmd_op_e;

    localparam int REC_MODE_W = 2;

    typedef struct packed {
        logic por;
        logic forced;
        logic wdog;
        logic illop;
        logic illadr;
    } rst_cause_t;

    typedef struct packed {
        logic                  secure;
        logic                  dbg_en;
        logic                  forced_halt;
        logic                  wdog_halt;
        logic                  illop_halt;
        logic                  illadr_halt;
        logic                  bkpt_halt;
        logic [REC_MODE_W-1:0] rec_mode;
    } ctl_t;

    typedef struct packed {
        logic accept;
        logic reject;
        logic background;
        logic go;
        logic step;
    } cmd_result_t;

    function automatic logic is_executing(core_state_e s);
        return (s == ST_RUN) || (s == ST_STEP);
    endfunction

    function automatic logic trace_mode_halts(logic [REC_MODE_W-1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb
    import dbg_ctl_pkg::*;
(
    input  rst_cause_t  rc,
    input  logic        pin_low,
    input  ctl_t        ctl,
    input  core_state_e st,
    input  logic        halt_insn,
    input  logic        bkpt_trig,
    input  logic        trace_full,
    input  logic        bg_accepted,
    output logic        any_reset,
    output logic        reset_halt,
    output logic        event_halt
);
    logic ev_insn, ev_bkpt, ev_trace;

    always_comb begin
        any_reset  = |rc;
        reset_halt = (rc.por    & pin_low)
                   | (rc.forced & (pin_low | ctl.forced_halt))
                   | (rc.wdog   & ctl.wdog_halt)
                   | (rc.illop  & ctl.illop_halt)
                   | (rc.illadr & ctl.illadr_halt);
        ev_insn    = halt_insn & ctl.dbg_en;
        ev_bkpt    = bkpt_trig & ctl.bkpt_halt;
        ev_trace   = trace_full & trace_mode_halts(ctl.rec_mode);
        event_halt = bg_accepted | (is_executing(st) & (ev_insn | ev_bkpt | ev_trace));
    end

    // R4: a masked fault cause never requests halt by itself
    always_comb begin
        if (rc == '{por: 1'b0, forced: 1'b0, wdog: 1'b1, illop: 1'b0, illadr: 1'b0} && !ctl.wdog_halt)
            p_wdog_masked_r4: assert (!reset_halt);
    end
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
    import dbg_ctl_pkg::*;
(
    input  logic        cmd_valid,
    input  cmd_class_e  cls,
    input  cmd_op_e     op,
    input  ctl_t        ctl,
    input  core_state_e st,
    output cmd_result_t res
);
    logic dbg_ok, allowed;

    always_comb begin
        dbg_ok = !ctl.secure && ctl.dbg_en;
        unique case (cls)
            CL_ALWAYS:  allowed = 1'b1;
            CL_NONINTR: allowed = dbg_ok && ((st != ST_LOWPWR) || (op == OP_BACKGROUND));
            CL_ACTIVE:  allowed = dbg_ok && (st == ST_HALT);
            default:    allowed = 1'b0;
        endcase
        res.accept     = cmd_valid && allowed;
        res.reject     = cmd_valid && !allowed;
        res.background = res.accept && (cls == CL_NONINTR) && (op == OP_BACKGROUND);
        res.go         = res.accept && (cls == CL_ACTIVE) && (op == OP_GO);
        res.step       = res.accept && (cls == CL_ACTIVE) && (op == OP_STEP);
    end

    // R11: the active class never goes through outside halt
    always_comb begin
        if (cmd_valid && cls == CL_ACTIVE && st != ST_HALT)
            p_active_needs_halt_r11: assert (!res.accept);
    end
endmodule

// File: rtl/dbg_state_fsm.sv
module dbg_state_fsm
    import dbg_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        any_reset,
    input  logic        reset_halt,
    input  logic        event_halt,
    input  cmd_result_t cmd,
    input  logic        sleep_req,
    input  logic        wake_req,
    input  logic        insn_done,
    output core_state_e state,
    output logic        halt_req,
    output logic        acc_q,
    output logic        rej_q
);
    core_state_e nxt;

    always_comb begin
        nxt = state;
        if (any_reset) begin
            nxt = reset_halt ? ST_HALT : ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (event_halt)     nxt = ST_HALT;
                    else if (sleep_req) nxt = ST_LOWPWR;
                end
                ST_LOWPWR: begin
                    if (event_halt)     nxt = ST_HALT;
                    else if (wake_req)  nxt = ST_RUN;
                end
                ST_HALT: begin
                    if (cmd.go)         nxt = ST_RUN;
                    else if (cmd.step)  nxt = ST_STEP;
                end
                default: begin
                    if (event_halt || insn_done) nxt = ST_HALT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            halt_req <= 1'b0;
            acc_q    <= 1'b0;
            rej_q    <= 1'b0;
        end else begin
            state    <= nxt;
            halt_req <= (nxt == ST_HALT) && ((state != ST_HALT) || any_reset);
            acc_q    <= cmd.accept;
            rej_q    <= cmd.reject;
        end
    end

    p_halt_pulse_state_r14: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (state == ST_HALT));

    p_step_done_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STEP && insn_done && !any_reset) |=> (state == ST_HALT));

    p_pulse_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(acc_q && rej_q));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_por,
    input  logic       rst_forced,
    input  logic       rst_wdog,
    input  logic       rst_illop,
    input  logic       rst_illadr,
    input  logic       pin_low,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_class,
    input  logic [1:0] cmd_op,
    input  logic       halt_insn,
    input  logic       bkpt_trig,
    input  logic       trace_full,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       insn_done,
    input  logic       ctl_secure,
    input  logic       ctl_dbg_en,
    input  logic       ctl_forced_halt,
    input  logic       ctl_wdog_halt,
    input  logic       ctl_illop_halt,
    input  logic       ctl_illadr_halt,
    input  logic       ctl_bkpt_halt,
    input  logic [1:0] ctl_rec_mode,
    output logic [1:0] core_state,
    output logic       halt_req,
    output logic       cmd_accept,
    output logic       cmd_reject
);
    rst_cause_t  rc;
    ctl_t        ctl;
    cmd_result_t cres;
    core_state_e st;
    logic        any_reset, reset_halt, event_halt;

    assign rc  = '{por: rst_por, forced: rst_forced, wdog: rst_wdog,
                   illop: rst_illop, illadr: rst_illadr};
    assign ctl = '{secure: ctl_secure, dbg_en: ctl_dbg_en, forced_halt: ctl_forced_halt,
                   wdog_halt: ctl_wdog_halt, illop_halt: ctl_illop_halt,
                   illadr_halt: ctl_illadr_halt, bkpt_halt: ctl_bkpt_halt,
                   rec_mode: ctl_rec_mode};

    dbg_cmd_gate u_gate (
        .cmd_valid (cmd_valid),
        .cls       (cmd_class_e'(cmd_class)),
        .op        (cmd_op_e'(cmd_op)),
        .ctl       (ctl),
        .st        (st),
        .res       (cres)
    );

    dbg_halt_arb u_arb (
        .rc          (rc),
        .pin_low     (pin_low),
        .ctl         (ctl),
        .st          (st),
        .halt_insn   (halt_insn),
        .bkpt_trig   (bkpt_trig),
        .trace_full  (trace_full),
        .bg_accepted (cres.background),
        .any_reset   (any_reset),
        .reset_halt  (reset_halt),
        .event_halt  (event_halt)
    );

    dbg_state_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .any_reset  (any_reset),
        .reset_halt (reset_halt),
        .event_halt (event_halt),
        .cmd        (cres),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .insn_done  (insn_done),
        .state      (st),
        .halt_req   (halt_req),
        .acc_q      (cmd_accept),
        .rej_q      (cmd_reject)
    );

    assign core_state = st;

    p_always_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_class == 2'd0) |=> cmd_accept);

    p_secure_reject_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ctl_secure && cmd_class != 2'd0) |=> cmd_reject);

    p_go_returns_run_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_class == 2'd2 && cmd_op == 2'd2 && !ctl_secure && ctl_dbg_en
         && core_state == 2'd2 && !rst_por && !rst_forced && !rst_wdog && !rst_illop
         && !rst_illadr) |=> (core_state == 2'd0));

    p_por_pin_r2: assert property (@(posedge clk) disable iff (rst)
        (rst_por && pin_low) |=> (core_state == 2'd2 && halt_req));
endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic rst_por, rst_forced, rst_wdog, rst_illop, rst_illadr, pin_low;
    logic cmd_valid;
    logic [1:0] cmd_class, cmd_op;
    logic halt_insn, bkpt_trig, trace_full, sleep_req, wake_req, insn_done;
    logic ctl_secure, ctl_dbg_en, ctl_forced_halt, ctl_wdog_halt, ctl_illop_halt;
    logic ctl_illadr_halt, ctl_bkpt_halt;
    logic [1:0] ctl_rec_mode;
    logic [1:0] core_state;
    logic halt_req, cmd_accept, cmd_reject;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_halt_ctrl u_dut (.*);

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        rst_por = 0; rst_forced = 0; rst_wdog = 0; rst_illop = 0; rst_illadr = 0;
        cmd_valid = 0; cmd_class = 0; cmd_op = 0;
        halt_insn = 0; bkpt_trig = 0; trace_full = 0;
        sleep_req = 0; wake_req = 0; insn_done = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic send_cmd(int cls, int op);
        cmd_valid = 1; cmd_class = 2'(cls); cmd_op = 2'(op);
        tick();
    endtask

    task automatic to_run();
        pin_low = 0; rst_por = 1;
        tick();
    endtask

    task automatic to_halt();
        send_cmd(1, 1);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        check("R1 state in reset", core_state, 0);
        rst = 0;
        @(negedge clk);
        check("R1 state after reset", core_state, 0);
        check("R1 halt_req", halt_req, 0);
        check("R1 accept", cmd_accept, 0);
        check("R1 reject", cmd_reject, 0);
    endtask

    task automatic t_por();
        pin_low = 0; rst_por = 1; tick();
        check("R2 por pin high", core_state, 0);
        pin_low = 1; rst_por = 1; tick();
        check("R2 por pin low", core_state, 2);
        check("R14 halt_req on entry", halt_req, 1);
        tick();
        check("R14 halt_req one cycle", halt_req, 0);
        check("R2 stays halted", core_state, 2);
        pin_low = 1; rst_por = 1; tick();
        check("R14 reset re-entry pulse", halt_req, 1);
        pin_low = 0;
    endtask

    task automatic t_forced();
        pin_low = 0; ctl_forced_halt = 0; rst_forced = 1; tick();
        check("R3 forced no halt", core_state, 0);
        ctl_forced_halt = 1; rst_forced = 1; tick();
        check("R3 forced with enable", core_state, 2);
        to_run();
        ctl_forced_halt = 0; pin_low = 1; rst_forced = 1; tick();
        check("R3 forced pin low", core_state, 2);
        pin_low = 0;
        to_run();
    endtask

    task automatic t_faults();
        rst_wdog = 1; tick();
        check("R4 wdog masked", core_state, 0);
        ctl_wdog_halt = 1; rst_wdog = 1; tick();
        check("R4 wdog enabled", core_state, 2);
        rst_illop = 1; tick();
        check("R4 illop masked", core_state, 0);
        ctl_illop_halt = 1; rst_illop = 1; tick();
        check("R4 illop enabled", core_state, 2);
        rst_illadr = 1; tick();
        check("R4 illadr masked", core_state, 0);
        ctl_illadr_halt = 1; rst_illadr = 1; tick();
        check("R4 illadr enabled", core_state, 2);
        ctl_wdog_halt = 0; ctl_illop_halt = 0; ctl_illadr_halt = 0;
        to_run();
    endtask

    task automatic t_priority();
        rst_wdog = 1; cmd_valid = 1; cmd_class = 1; cmd_op = 1; bkpt_trig = 1;
        ctl_bkpt_halt = 1; tick();
        check("R5 reset wins over background", core_state, 0);
        check("R5 command still answered", cmd_accept, 1);
        ctl_bkpt_halt = 0;
    endtask

    task automatic t_sleep_bg();
        sleep_req = 1; tick();
        check("R6 sleep", core_state, 1);
        send_cmd(1, 0);
        check("R10 plain nonintr in lowpwr", cmd_reject, 1);
        check("R13 reject keeps state", core_state, 1);
        wake_req = 1; tick();
        check("R6 wake", core_state, 0);
        sleep_req = 1; tick();
        send_cmd(1, 1);
        check("R6 background wakes to halt", core_state, 2);
        check("R10 background accepted in lowpwr", cmd_accept, 1);
        tick();
        check("R13 accept one cycle", cmd_accept, 0);
    endtask

    task automatic t_active();
        send_cmd(2, 0);
        check("R11 active in halt", cmd_accept, 1);
        check("R11 stays halted", core_state, 2);
        send_cmd(3, 0);
        check("R11 reserved class", cmd_reject, 1);
        send_cmd(2, 2);
        check("R11 go", core_state, 0);
        send_cmd(2, 0);
        check("R11 active in run", cmd_reject, 1);
        check("R13 reject in run keeps state", core_state, 0);
        send_cmd(1, 0);
        check("R10 nonintr in run", cmd_accept, 1);
    endtask

    task automatic t_step();
        to_halt();
        send_cmd(2, 3);
        check("R12 step", core_state, 3);
        tick();
        check("R12 step holds", core_state, 3);
        insn_done = 1; tick();
        check("R12 back to halt", core_state, 2);
        check("R14 pulse after step", halt_req, 1);
        send_cmd(2, 2);
    endtask

    task automatic t_insn();
        ctl_dbg_en = 0; halt_insn = 1; tick();
        check("R7 halt insn disabled", core_state, 0);
        ctl_dbg_en = 1; halt_insn = 1; tick();
        check("R7 halt insn enabled", core_state, 2);
        send_cmd(2, 2);
    endtask

    task automatic t_bkpt_trace();
        ctl_bkpt_halt = 0; bkpt_trig = 1; tick();
        check("R8 bkpt masked", core_state, 0);
        ctl_bkpt_halt = 1; bkpt_trig = 1; tick();
        check("R8 bkpt halts", core_state, 2);
        send_cmd(2, 2);
        ctl_bkpt_halt = 0;
        ctl_rec_mode = 2'b10; trace_full = 1; tick();
        check("R8 trace mode 10", core_state, 0);
        ctl_rec_mode = 2'b00; trace_full = 1; tick();
        check("R8 trace mode 00", core_state, 0);
        ctl_rec_mode = 2'b01; trace_full = 1; tick();
        check("R8 trace mode 01", core_state, 2);
        send_cmd(2, 2);
        ctl_rec_mode = 2'b11; trace_full = 1; tick();
        check("R8 trace mode 11", core_state, 2);
        send_cmd(2, 2);
        ctl_rec_mode = 2'b00;
    endtask

    task automatic t_gating();
        to_halt();
        ctl_secure = 1;
        send_cmd(0, 0);
        check("R9 always class when secure", cmd_accept, 1);
        send_cmd(1, 0);
        check("R10 nonintr when secure", cmd_reject, 1);
        send_cmd(2, 2);
        check("R11 go rejected when secure", cmd_reject, 1);
        check("R13 secure reject keeps halt", core_state, 2);
        ctl_secure = 0; ctl_dbg_en = 0;
        send_cmd(1, 0);
        check("R10 nonintr debug disabled", cmd_reject, 1);
        send_cmd(0, 0);
        check("R9 always class debug disabled", cmd_accept, 1);
        ctl_dbg_en = 1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        clear_strobes();
        rst = 1; pin_low = 0;
        ctl_secure = 0; ctl_dbg_en = 1; ctl_forced_halt = 0; ctl_wdog_halt = 0;
        ctl_illop_halt = 0; ctl_illadr_halt = 0; ctl_bkpt_halt = 0; ctl_rec_mode = 0;
        @(negedge clk);
        t_reset();
        t_por();
        t_forced();
        t_faults();
        t_priority();
        t_sleep_bg();
        t_active();
        t_step();
        t_insn();
        t_bkpt_trace();
        t_gating();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule